// File: doc/BRIEF.md
# Memory-Mapped GPIO Port

This block is one port of general-purpose pins that a processor controls through a small memory-mapped register bus. Software writes a level register and a direction register. The port turns these into a per-pin drive value and a per-pin drive enable for the pad logic. Software also reads a sampled view of the pin levels, which is the only view of the pins that the bus exposes.

Pad inputs arrive with no timing relation to the system clock. Each one passes through two flip-flops in series before a capture register takes it, and the bus reads only that capture register. The port does not decide which peripheral owns a pin. A separate pin multiplexer makes that choice, so the stored output level may not match what the pin actually shows.

Top module: `gpio_port`

## Requirements
- R1: While reset is asserted, and on the cycle after it, pad_oe, pad_out and bus_rdata are all zero. Every pin therefore starts as an undriven input.
- R2: A write with bus_wr high to offset 0x4 updates the level register on that clock edge, and pad_out shows the new value from the next cycle on. A read of 0x4 returns the stored value.
- R3: A write to offset 0x8 updates the direction register, where bit value 1 means output and 0 means input. Bit i of pad_oe equals bit i of the direction register, and a read of 0x8 returns it.
- R4: For any pin whose direction bit is 0, pad_oe is 0 whatever the level register holds. A read of 0x4 still returns the stored level, not the pin level.
- R5: A read of offset 0x0 returns pad_in after two synchronizer stages and a capture stage. A pad change made before clock edge k is returned by a read whose strobe is sampled at edge k+3. A read sampled at edge k+2 still returns the old value.
- R6: Writes to offset 0x0 and to any unmapped offset change neither the level register nor the direction register.
- R7: A read returns data on bus_rdata in the cycle after the edge that samples bus_rd. bus_rdata is zero in any cycle that follows an edge without a read, and zero after a read of an unmapped offset.
- R8: The level and direction registers each hold their value until software writes that same register again. Writes to the other register do not disturb them.
- R9: A read of 0x0 shows the pad level even when it differs from the level register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | N_PINS | Write data |
| bus_rdata | output | N_PINS | Registered read data |
| pad_in | input | N_PINS | Asynchronous pad levels |
| pad_out | output | N_PINS | Level to drive per pin |
| pad_oe | output | N_PINS | Drive enable per pin |

## Verification
The assertions assume that bus_rd and bus_wr are never high in the same cycle. They also assume that pad_in and the bus signals change away from the rising edge, so the reference latency of three edges from pad to capture is exact. The bench drives every input on the falling edge and issues reads and writes as separate single-cycle strobes. It sweeps all 256 values of an 8-pin port through each register and through the pads.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam logic [15:0] OFF_PINS  = 16'h0;
    localparam logic [15:0] OFF_LEVEL = 16'h4;
    localparam logic [15:0] OFF_DIR   = 16'h8;

    typedef enum logic [1:0] {
        SEL_PINS  = 2'd0,
        SEL_LEVEL = 2'd1,
        SEL_DIR   = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_sel_e sel;
    } bus_req_t;

    function automatic reg_sel_e decode_offset(input logic [15:0] off);
        reg_sel_e s;
        case (off)
            OFF_PINS:  s = SEL_PINS;
            OFF_LEVEL: s = SEL_LEVEL;
            OFF_DIR:   s = SEL_DIR;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int N_PINS = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] pins_q
);
    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], pad_in[p]};
        end
        always_ff @(posedge clk) begin
            if (rst) pins_q[p] <= 1'b0;
            else     pins_q[p] <= chain[STAGES-1];
        end
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [N_PINS-1:0] wdata,
    output logic [N_PINS-1:0] level_q,
    output logic [N_PINS-1:0] dir_q
);
    logic wr_level, wr_dir;
    assign wr_level = req.wr && (req.sel == SEL_LEVEL);
    assign wr_dir   = req.wr && (req.sel == SEL_DIR);

    always_ff @(posedge clk) begin
        if (rst)           level_q <= '0;
        else if (wr_level) level_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)         dir_q <= '0;
        else if (wr_dir) dir_q <= wdata;
    end

    AST_LEVEL_WRITE: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == SEL_LEVEL) |=> level_q == $past(wdata)); // R2
    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(req.wr && req.sel == SEL_LEVEL) |=> $stable(level_q)); // R8
    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(req.wr && req.sel == SEL_DIR) |=> $stable(dir_q)); // R8
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
    import gpio_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [N_PINS-1:0] pins_q,
    input  logic [N_PINS-1:0] level_q,
    input  logic [N_PINS-1:0] dir_q,
    output logic [N_PINS-1:0] rdata
);
    logic [N_PINS-1:0] sel_data;

    always_comb begin
        case (req.sel)
            SEL_PINS:  sel_data = pins_q;
            SEL_LEVEL: sel_data = level_q;
            SEL_DIR:   sel_data = dir_q;
            default:   sel_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata <= '0;
        else if (req.rd) rdata <= sel_data;
        else             rdata <= '0;
    end

    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req.rd |=> rdata == '0); // R7
    AST_RD_UNMAPPED: assert property (@(posedge clk) disable iff (rst)
        (req.rd && req.sel == SEL_NONE) |=> rdata == '0); // R7
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int N_PINS = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [N_PINS-1:0] bus_wdata,
    output logic [N_PINS-1:0] bus_rdata,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_oe
);
    localparam int SYNC_STAGES = 2;
    localparam int PIPE_LAT    = SYNC_STAGES + 1;

    bus_req_t          req;
    logic [N_PINS-1:0] pins_q, level_q, dir_q;

    assign req.rd  = bus_rd;
    assign req.wr  = bus_wr;
    assign req.sel = decode_offset(16'(bus_addr));

    gpio_sync #(.N_PINS(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pad_in(pad_in), .pins_q(pins_q)
    );

    gpio_regs #(.N_PINS(N_PINS)) u_regs (
        .clk(clk), .rst(rst), .req(req), .wdata(bus_wdata),
        .level_q(level_q), .dir_q(dir_q)
    );

    gpio_rdmux #(.N_PINS(N_PINS)) u_rdmux (
        .clk(clk), .rst(rst), .req(req), .pins_q(pins_q),
        .level_q(level_q), .dir_q(dir_q), .rdata(bus_rdata)
    );

    assign pad_out = level_q;
    assign pad_oe  = dir_q;

    // cycles since reset, saturating, for the latency check
    logic [2:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)                    age_q <= '0;
        else if (age_q != 3'd7)     age_q <= age_q + 3'd1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (pad_oe == '0 && pad_out == '0 && bus_rdata == '0)); // R1
    AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && 16'(bus_addr) == OFF_DIR) |=> pad_oe == $past(bus_wdata)); // R3
    AST_RO_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && 16'(bus_addr) == OFF_PINS) |=> ($stable(pad_out) && $stable(pad_oe))); // R6
    AST_PIN_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 3'(PIPE_LAT + 1)) |-> pins_q == $past(pad_in, 3)); // R5
    AST_NO_RDWR: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr)); // R7
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
    localparam int N = 8;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_rd = 1'b0;
    logic          bus_wr = 1'b0;
    logic [N-1:0]  bus_wdata = '0;
    logic [N-1:0]  bus_rdata;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_out;
    logic [N-1:0]  pad_oe;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    gpio_port #(.N_PINS(N), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [N-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        logic [N-1:0] r;
        logic [N-1:0] lvl_ref;
        logic [N-1:0] dir_ref;
        repeat (3) @(negedge clk);
        check("R1 pad_oe", pad_oe, '0);
        check("R1 pad_out", pad_out, '0);
        check("R1 rdata", bus_rdata, '0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 pad_oe after", pad_oe, '0);
        bus_read(4'h8, r); check("R1 dir read", r, '0);
        bus_read(4'h4, r); check("R1 level read", r, '0);

        for (int v = 0; v < 256; v++) begin
            bus_write(4'h4, N'(v));
            check("R2 pad_out", pad_out, N'(v));
            bus_read(4'h4, r); check("R2 readback", r, N'(v));
        end
        lvl_ref = 8'h5A;
        bus_write(4'h4, lvl_ref);

        for (int v = 0; v < 256; v++) begin
            bus_write(4'h8, N'(v));
            check("R3 pad_oe", pad_oe, N'(v));
            bus_read(4'h8, r); check("R3 readback", r, N'(v));
            check("R8 level kept", pad_out, lvl_ref);
        end
        dir_ref = 8'h0F;
        bus_write(4'h8, dir_ref);
        bus_write(4'h4, 8'hFF);
        check("R4 oe gated", pad_oe, 8'h0F);
        check("R8 dir kept", pad_oe & ~dir_ref, '0);
        bus_write(4'h8, 8'h00);
        check("R4 all input", pad_oe, '0);
        pad_in = 8'h00;
        bus_read(4'h4, r); check("R4 stored level", r, 8'hFF);
        bus_write(4'h8, dir_ref);

        bus_write(4'h0, 8'h33);
        check("R6 ro level", pad_out, 8'hFF);
        check("R6 ro dir", pad_oe, dir_ref);
        for (int a = 0; a < 16; a++) begin
            if (a == 0 || a == 4 || a == 8) continue;
            bus_write(AW'(a), 8'hC3);
            check("R6 unmapped level", pad_out, 8'hFF);
            check("R6 unmapped dir", pad_oe, dir_ref);
            bus_read(AW'(a), r); check("R7 unmapped read", r, '0);
        end
        @(negedge clk);
        check("R7 idle rdata", bus_rdata, '0);

        for (int v = 0; v < 256; v++) begin
            @(negedge clk);
            pad_in = N'(v);
            repeat (2) @(negedge clk);
            bus_read(4'h0, r); check("R5 pins", r, N'(v));
        end
        @(negedge clk);
        pad_in = 8'hA5;
        @(negedge clk);
        bus_read(4'h0, r); check("R5 early read old", r, 8'hFF);
        bus_read(4'h0, r); check("R5 later read new", r, 8'hA5);
        bus_read(4'h4, r); check("R9 level not pins", r, 8'hFF);
        bus_read(4'h0, r); check("R9 pins not level", r, 8'hA5);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule